// File: doc/BRIEF.md
# Oscillator stabilization wait controller

This block owns the 8-bit control register of a high-speed and a low-speed oscillator. It also holds back the high-speed clock from the rest of the chip until the oscillator has had time to settle. A 4-bit select field picks the settling time from a set of power-of-two lengths. A down-counter clocked by the oscillator itself measures that time. When the count runs out, the block raises a ready flag and opens a clock enable for the system.

The settling wait is started in two ways: by reset, and by leaving sleep mode (the falling edge of `sleep_i`). When software turns the high-speed oscillator on through its enable bit, the counter is skipped and the clock is declared ready at once. In that case software is expected to provide its own delay. The select field and the low-speed enable are protected: a write reaches them only while `unlock_i` is high. The high-speed enable bit is always writable.

Top module: `osc_wait_ctrl`

## Requirements
- R1: The wait length is N = 2^(BASE_EXP + 15 - code) oscillator cycles, where code is read from register bits 7:4. With the default BASE_EXP = 7, code 0xF gives 128 cycles and code 0x0 gives 4,194,304 cycles.
- R2: While `rst_ni` is low, the register reads 0xF3 and both `clk_ready_o` and `sys_clk_en_o` are low. After reset is released, `clk_ready_o` is high after the N-th rising edge, with N taken for code 0xF.
- R3: A falling edge of `sleep_i` while the high-speed enable (bit 0) is set starts a wait. `clk_ready_o` goes high after the (N+1)-th rising edge, counting from the first edge at which `sleep_i` is low. It stays low before that edge.
- R4: When a write sets bit 0 from 0 to 1 while `sleep_i` is low, `clk_ready_o` goes high one edge after the write edge, with no counted wait.
- R5: When a write clears bit 0, `sys_clk_en_o` is low right after the write edge and `clk_ready_o` is low one edge later. While `sleep_i` is high, both outputs are low from the next edge on.
- R6: A write with `sel_i` and `we_i` high always updates bit 0. It updates bits 7:4 and bit 1 only when `unlock_i` is high; otherwise those bits keep their value.
- R7: With `sel_i` high, `rdata_o` is {code[3:0], 2'b00, low-speed enable, high-speed enable}. Bits 3:2 always read 0. With `sel_i` low, `rdata_o` is 0.
- R8: A change of the select field during a wait does not change that wait's length. It applies to the next wait.
- R9: A wake from sleep while bit 0 is clear leaves `clk_ready_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | High-speed oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Register select (address decode) |
| we_i | input | 1 | Write enable |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| unlock_i | input | 1 | Opens write access to protected bits |
| sleep_i | input | 1 | Sleep mode request; its falling edge is the wake event |
| osc_hi_en_o | output | 1 | High-speed oscillator enable |
| osc_lo_en_o | output | 1 | Low-speed oscillator enable |
| clk_ready_o | output | 1 | High-speed clock settled |
| sys_clk_en_o | output | 1 | Gated clock enable toward the system |

## Verification
The bench builds the block with BASE_EXP = 1, so the wait lengths span 2 to 65,536 cycles instead of 128 to 4,194,304. This brings every select code, including the longest one (code 0x0), within the run length. The exact ready cycle for each code is measured edge by edge. Random wake sequences use codes 4 to 15 mixed with locked and unlocked writes. Directed cases cover a select change during a wait, a wake with the oscillator disabled, and a software turn-on.

// File: rtl/osc_wait_pkg.sv
package osc_wait_pkg;
  localparam int CODE_W = 4;
  localparam int REG_W  = 8;
  localparam logic [CODE_W-1:0] RST_CODE = 4'hf;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_READY
  } wait_st_e;
endpackage

// File: rtl/osc_ctl_reg.sv
module osc_ctl_reg
  import osc_wait_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              unlock_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [CODE_W-1:0] code_o,
  output logic              lo_en_o,
  output logic              hi_en_o
);
  logic wr;
  assign wr = sel_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o  <= RST_CODE;
      lo_en_o <= 1'b1;
      hi_en_o <= 1'b1;
    end else if (wr) begin
      hi_en_o <= wdata_i[0];
      if (unlock_i) begin
        code_o  <= wdata_i[REG_W-1 -: CODE_W];
        lo_en_o <= wdata_i[1];
      end
    end
  end

  assign rdata_o = sel_i ? {code_o, 2'b00, lo_en_o, hi_en_o} : '0;

  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !unlock_i) |=> ($stable(code_o) && $stable(lo_en_o))); // R6
  AST_HI_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr |=> (hi_en_o == $past(wdata_i[0]))); // R6
endmodule

// File: rtl/osc_wait_timer.sv
module osc_wait_timer
  import osc_wait_pkg::*;
#(
  parameter int BASE_EXP = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hi_en_i,
  input  logic              sleep_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              ready_o
);
  localparam int SPAN  = (1 << CODE_W) - 1;
  localparam int CNT_W = BASE_EXP + SPAN + 1;

  function automatic logic [CNT_W-1:0] load_val(input logic [CODE_W-1:0] c);
    int sh;
    sh = BASE_EXP + SPAN - int'(c);
    return (CNT_W'(1) << sh) - CNT_W'(1);
  endfunction

  wait_st_e         state;
  logic [CNT_W-1:0] cnt;
  logic             sleep_q, hi_q;
  logic             awake, wake, hi_rise;

  assign awake   = !sleep_i && hi_en_i;
  assign wake    = sleep_q && !sleep_i;
  assign hi_rise = hi_en_i && !hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sleep_q <= 1'b0;
      hi_q    <= 1'b1;
    end else begin
      sleep_q <= sleep_i;
      hi_q    <= hi_en_i;
    end
  end

  // wait armed only by reset or wake; sw turn-on skips the counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_WAIT;
      cnt   <= load_val(RST_CODE);
    end else if (!awake) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (wake) begin
      state <= ST_WAIT;
      cnt   <= load_val(code_i);
    end else if (hi_rise) begin
      state <= ST_READY;
    end else if (state == ST_WAIT) begin
      if (cnt == '0) state <= ST_READY;
      else           cnt   <= cnt - CNT_W'(1);
    end
  end

  assign ready_o = (state == ST_READY);

  AST_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !awake |=> !ready_o); // R5
  AST_WAKE_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake && hi_en_i) |=> !ready_o); // R3
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WAIT && cnt != '0 && awake && !wake) |=> (cnt == $past(cnt) - CNT_W'(1))); // R1
  AST_RDY_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WAIT && cnt == '0 && awake && !wake) |=> ready_o); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && !hi_rise) |=> !ready_o); // R9
endmodule

// File: rtl/osc_wait_ctrl.sv
module osc_wait_ctrl
  import osc_wait_pkg::*;
#(
  parameter int BASE_EXP = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       unlock_i,
  input  logic       sleep_i,
  output logic       osc_hi_en_o,
  output logic       osc_lo_en_o,
  output logic       clk_ready_o,
  output logic       sys_clk_en_o
);
  logic [CODE_W-1:0] code;

  osc_ctl_reg u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_i),
    .we_i     (we_i),
    .wdata_i  (wdata_i),
    .unlock_i (unlock_i),
    .rdata_o  (rdata_o),
    .code_o   (code),
    .lo_en_o  (osc_lo_en_o),
    .hi_en_o  (osc_hi_en_o)
  );

  osc_wait_timer #(.BASE_EXP(BASE_EXP)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hi_en_i (osc_hi_en_o),
    .sleep_i (sleep_i),
    .code_i  (code),
    .ready_o (clk_ready_o)
  );

  assign sys_clk_en_o = clk_ready_o & osc_hi_en_o & ~sleep_i;

  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[3:2] == 2'b00); // R7
endmodule

// File: tb/osc_wait_ctrl_tb.sv
module osc_wait_ctrl_tb_top;
  localparam int CLK_PER  = 10;
  localparam int BASE_EXP = 1;
  localparam int WDOG     = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, we = 1'b0, unlock = 1'b0, sleep = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       hi_en, lo_en, ready, sys_en;

  int total = 0, bad = 0, cyc = 0;
  logic [3:0] m_code = 4'hf;
  logic       m_lo = 1'b1, m_hi = 1'b1;

  always #(CLK_PER/2) clk = ~clk;

  osc_wait_ctrl #(.BASE_EXP(BASE_EXP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .unlock_i(unlock), .sleep_i(sleep),
    .osc_hi_en_o(hi_en), .osc_lo_en_o(lo_en), .clk_ready_o(ready), .sys_clk_en_o(sys_en)
  );

  function automatic int exp_n(input logic [3:0] c);
    return 1 << (BASE_EXP + 15 - int'(c));
  endfunction

  function automatic logic [7:0] exp_rd();
    return {m_code, 2'b00, m_lo, m_hi};
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic unl);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; wdata = d; unlock = unl;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; we = 1'b0; unlock = 1'b0;
    m_hi = d[0];
    if (unl) begin m_code = d[7:4]; m_lo = d[1]; end
  endtask

  task automatic rd_chk(input string req);
    @(negedge clk);
    sel = 1'b1;
    #1;
    chk(req, rdata, exp_rd());
    sel = 1'b0;
    #1;
    chk({req, " unselected"}, rdata, 0);
  endtask

  // counts rising edges until ready; optional register write at edge chg_at
  task automatic measure(input int lim, input int chg_at, input logic [7:0] chg_d, output int n);
    n = 0;
    while (1) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (chg_at != 0 && n == chg_at) begin
        sel = 1'b1; we = 1'b1; wdata = chg_d; unlock = 1'b1;
      end else if (chg_at != 0 && n == chg_at + 1) begin
        sel = 1'b0; we = 1'b0; unlock = 1'b0;
        m_code = chg_d[7:4]; m_lo = chg_d[1]; m_hi = chg_d[0];
      end
      if (ready || n > lim) break;
    end
  endtask

  task automatic sleep_wake(input int hold);
    @(negedge clk);
    sleep = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R5 sleep ready", ready, 0);
    chk("R5 sleep sys_en", sys_en, 0);
    for (int i = 0; i < hold; i++) @(negedge clk);
    sleep = 1'b0;
  endtask

  initial begin
    int n;
    void'($urandom(32'd1234));
    // reset state
    repeat (3) @(negedge clk);
    sel = 1'b1; #1;
    chk("R2 reset rdata", rdata, 8'hf3);
    chk("R2 reset ready", ready, 0);
    chk("R2 reset sys_en", sys_en, 0);
    sel = 1'b0;
    rst_n = 1'b1;
    measure(64, 0, 8'h0, n);
    chk("R2 reset wait", n, exp_n(4'hf));
    chk("R5 sys_en when ready", sys_en, 1);

    // locked clear of hi enable, protected bits untouched
    @(negedge clk);
    sel = 1'b1; we = 1'b1; wdata = 8'h00; unlock = 1'b0;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
    m_hi = 1'b0;
    chk("R5 sys_en drop", sys_en, 0);
    @(posedge clk); @(negedge clk);
    chk("R5 ready drop", ready, 0);
    rd_chk("R6 locked write");

    // software turn-on: no counted wait
    wr(8'h01, 1'b0);
    chk("R4 not before", ready, 0);
    @(posedge clk); @(negedge clk);
    chk("R4 sw enable ready", ready, 1);

    // unlocked write then wake wait
    wr(8'ha3, 1'b1);
    rd_chk("R7 readback");
    chk("R6 lo enable", lo_en, 1);
    sleep_wake(3);
    measure(exp_n(4'ha) + 8, 0, 8'h0, n);
    chk("R3 wake wait code a", n, exp_n(4'ha) + 1);

    // longest code
    wr(8'h01, 1'b1);
    rd_chk("R6 unlocked write");
    chk("R6 lo cleared", lo_en, 0);
    sleep_wake(1);
    measure(exp_n(4'h0) + 8, 0, 8'h0, n);
    chk("R1 code 0 wait", n, exp_n(4'h0) + 1);

    // select change mid-wait applies next time only
    wr(8'hc3, 1'b1);
    sleep_wake(2);
    measure(exp_n(4'hc) + 8, 5, 8'h33, n);
    chk("R8 mid-wait change", n, exp_n(4'hc) + 1);
    rd_chk("R8 new code stored");
    sleep_wake(1);
    measure(exp_n(4'h3) + 8, 0, 8'h0, n);
    chk("R8 next wait uses new code", n, exp_n(4'h3) + 1);

    // wake while hi disabled
    wr(8'hf2, 1'b1);
    sleep_wake(2);
    repeat (40) @(negedge clk);
    chk("R9 no ready when disabled", ready, 0);
    chk("R9 sys_en when disabled", sys_en, 0);

    // random mix
    for (int it = 0; it < 12; it++) begin
      logic [3:0] c;
      logic [7:0] d;
      d = 8'($urandom);
      wr(d, 1'b0);
      rd_chk("R6 random locked");
      c = 4'(4 + ($urandom % 12));
      wr({c, 2'b00, 1'($urandom), 1'b1}, 1'b1);
      sleep_wake(int'($urandom % 4));
      measure(exp_n(c) + 8, 0, 8'h0, n);
      chk("R1 random wait", n, exp_n(c) + 1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, WDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule